// File: doc/BRIEF.md
# Self-Routing Omega Switch Fabric with Input Queues

This block moves fixed-size packets from N = 2^n input ports to N output ports through n stages of 2x2 switching elements. Stages are joined by perfect-shuffle wiring, where line i connects to the index formed by rotating i left by one bit. Each element places its packets into one small queue per output line. The packets route themselves: the stage with number k (counting from 1) looks at destination bit n-k, so the most significant bit is used first. A 0 sends the packet to the upper output of the element and a 1 sends it to the lower output. Only one path exists between any input and any output.

Each network input has its own input queue of depth m. A source hands a packet in by asserting valid while the queue shows ready. A full queue drops ready, and the source must then hold its packet. When the first stage turns a packet down, it stays at the head of the input queue and is offered again in the next cycle. A stage queue that has no room holds off the queue feeding it in the same way, all the way back to the inputs, so no packet is ever dropped. A stage queue can take two packets in one cycle. When only one slot is free and both inputs of an element want the same queue, a two-state round-robin arbiter chooses between them. The network outputs never stall: each last-stage queue hands out its head packet in every cycle in which it holds one.

Each input queue has a three-state controller: EMPTY, HOLD and FULL. Its transitions are T_FILL (EMPTY to HOLD, or EMPTY to FULL when m = 1), T_TOP (HOLD to FULL), T_DRAIN (HOLD to EMPTY), T_RELEASE (FULL to HOLD) and T_FLUSH (FULL to EMPTY when m = 1). Each stage queue has a two-state arbiter: PRI_UPPER and PRI_LOWER. Its single transition is T_SWAP. T_SWAP fires on a one-slot conflict, after the preferred side has been served.

Top module: `omega_fabric`

## Requirements
- R1: A packet accepted on any input with destination d leaves on output d, with out_dest equal to d and its payload unchanged. The destination is n bits wide, and stage k routes on destination bit n-k after a left-rotate shuffle.
- R2: Every accepted packet is delivered exactly once. No packet is lost or duplicated under any load.
- R3: Packets that share a source and a destination leave in the order they were accepted.
- R4: A packet reaches its output at least n+1 clock edges after the edge on which it was accepted. The count runs from the acceptance edge to the edge on which the output hands it out. In an otherwise empty fabric the latency is exactly n+1.
- R5: The input ready for a port is high exactly when that queue's occupancy count is below m. The count never exceeds m, and it does not grow while ready is low.
- R6: A head packet that the next stage does not take stays in place, with its content unchanged, and is offered again in the next cycle. This applies to input queues and stage queues alike.
- R7: A stage queue accepts up to two packets per cycle. A full queue accepts a packet in the same cycle its head leaves. Under conflict-free full-rate traffic (destination equal to source), every output therefore delivers one packet per cycle, and a saturated hot-spot output is never idle.
- R8: When both inputs of an element compete for one free slot, the grant alternates between upper and lower. As a result, every source feeding a saturated hot spot receives roughly a 1/N share.
- R9: After reset, every input shows ready, every occupancy count is 0 and no output is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | N | Per-input packet offer |
| in_ready | output | N | Per-input queue has room |
| in_dest | input | N*n | Per-input destination address |
| in_data | input | N*PAY_W | Per-input payload |
| in_occ | output | N*clog2(m+1) | Per-input queue occupancy |
| out_valid | output | N | Packet delivered on this output this cycle |
| out_dest | output | N*n | Destination field of the delivered packet |
| out_data | output | N*PAY_W | Payload of the delivered packet |

## Verification
The hardest situation to reach is the one-slot conflict. Here a full stage queue is losing its head in the same cycle that both upstream inputs want it, while the input queues behind it are full and their sources are held. This case exercises the round-robin arbiter, same-cycle refill and resubmission at once. The bench reaches it by driving every source at full rate toward one hot output for several hundred cycles. It then checks that the hot output never idles, that every source gets a near-equal share, and that every held packet still arrives in order. Random uniform and skewed phases follow, and an exhaustive single-packet sweep over all source and destination pairs pins the exact n+1 latency.

// File: rtl/omega_pkg.sv
package omega_pkg;

    typedef enum logic [1:0] {
        IB_EMPTY,
        IB_HOLD,
        IB_FULL
    } ibc_state_e;

    typedef enum logic {
        PRI_UPPER,
        PRI_LOWER
    } arb_state_e;

    // perfect shuffle: rotate a line index left by one bit
    function automatic int shuffle_idx(input int idx, input int bits);
        int mask;
        mask = (1 << bits) - 1;
        return ((idx << 1) | (idx >> (bits - 1))) & mask;
    endfunction

endpackage

// File: rtl/omega_ibc.sv
module omega_ibc
    import omega_pkg::*;
#(
    parameter int PKT_W = 19,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_vld,
    input  logic [PKT_W-1:0]             push_pkt,
    output logic                         push_rdy,
    output logic                         head_vld,
    output logic [PKT_W-1:0]             head_pkt,
    input  logic                         head_take,
    output logic [$clog2(DEPTH+1)-1:0]   occ
);
    localparam int OCC_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [OCC_W-1:0] FULL_CNT = OCC_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    ibc_state_e        state_q, state_d;
    logic [OCC_W-1:0]  cnt_q, cnt_d;
    logic [PTR_W-1:0]  rd_q, wr_q;
    logic [PKT_W-1:0]  mem [DEPTH];
    logic              do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    // outputs decoded from the state
    always_comb begin
        push_rdy = 1'b1;
        head_vld = 1'b1;
        unique case (state_q)
            IB_EMPTY: head_vld = 1'b0;
            IB_HOLD:  ;
            IB_FULL:  push_rdy = 1'b0;
            default: begin
                push_rdy = 1'b0;
                head_vld = 1'b0;
            end
        endcase
    end

    assign do_push  = push_vld & push_rdy;
    assign do_pop   = head_take & head_vld;
    assign cnt_d    = cnt_q + OCC_W'(do_push) - OCC_W'(do_pop);
    assign head_pkt = mem[rd_q];
    assign occ      = cnt_q;

    // next-state arcs
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IB_EMPTY: if (do_push) state_d = (cnt_d == FULL_CNT) ? IB_FULL : IB_HOLD; // T_FILL
            IB_HOLD: begin
                if (cnt_d == '0)            state_d = IB_EMPTY;   // T_DRAIN
                else if (cnt_d == FULL_CNT) state_d = IB_FULL;    // T_TOP
            end
            IB_FULL: if (do_pop) state_d = (cnt_d == '0) ? IB_EMPTY : IB_HOLD; // T_FLUSH / T_RELEASE
            default: state_d = IB_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IB_EMPTY;
            cnt_q   <= '0;
            rd_q    <= '0;
            wr_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (do_push) wr_q <= bump(wr_q);
            if (do_pop)  rd_q <= bump(rd_q);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= push_pkt;
    end

endmodule

// File: rtl/omega_obuf.sv
module omega_obuf
    import omega_pkg::*;
#(
    parameter int PKT_W = 19,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_a,
    input  logic [PKT_W-1:0] pkt_a,
    input  logic             req_b,
    input  logic [PKT_W-1:0] pkt_b,
    output logic             gnt_a,
    output logic             gnt_b,
    output logic             head_vld,
    output logic [PKT_W-1:0] head_pkt,
    input  logic             pop
);
    localparam int OCC_W = $clog2(DEPTH + 1);
    localparam int RM_W  = OCC_W + 1;
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    arb_state_e        arb_q, arb_d;
    logic [OCC_W-1:0]  cnt_q;
    logic [RM_W-1:0]   room;
    logic [PTR_W-1:0]  rd_q, wr_q, wr_nx;
    logic [PKT_W-1:0]  mem [DEPTH];
    logic              wr0, wr1;
    logic [PKT_W-1:0]  dat0;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    // a departing head frees its slot for this cycle's arrivals
    assign room = RM_W'(DEPTH) - RM_W'(cnt_q) + RM_W'(pop);

    // arbiter: grants and the T_SWAP arc
    always_comb begin
        gnt_a = 1'b0;
        gnt_b = 1'b0;
        arb_d = arb_q;
        if (req_a && req_b) begin
            if (room >= RM_W'(2)) begin
                gnt_a = 1'b1;
                gnt_b = 1'b1;
            end else if (room == RM_W'(1)) begin
                unique case (arb_q)
                    PRI_UPPER: begin
                        gnt_a = 1'b1;
                        arb_d = PRI_LOWER;
                    end
                    PRI_LOWER: begin
                        gnt_b = 1'b1;
                        arb_d = PRI_UPPER;
                    end
                    default: arb_d = PRI_UPPER;
                endcase
            end
        end else if (req_a) begin
            gnt_a = (room != '0);
        end else if (req_b) begin
            gnt_b = (room != '0);
        end
    end

    assign wr0      = gnt_a | gnt_b;
    assign wr1      = gnt_a & gnt_b;
    assign dat0     = gnt_a ? pkt_a : pkt_b;
    assign wr_nx    = bump(wr_q);
    assign head_vld = (cnt_q != '0);
    assign head_pkt = mem[rd_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arb_q <= PRI_UPPER;
            cnt_q <= '0;
            rd_q  <= '0;
            wr_q  <= '0;
        end else begin
            arb_q <= arb_d;
            cnt_q <= cnt_q + OCC_W'(wr0) + OCC_W'(wr1) - OCC_W'(pop);
            if (wr1)      wr_q <= bump(wr_nx);
            else if (wr0) wr_q <= wr_nx;
            if (pop)      rd_q <= bump(rd_q);
        end
    end

    always_ff @(posedge clk) begin
        if (wr0) mem[wr_q]  <= dat0;
        if (wr1) mem[wr_nx] <= pkt_b;
    end

endmodule

// File: rtl/omega_stage.sv
module omega_stage
    import omega_pkg::*;
#(
    parameter int N_LOG = 3,
    parameter int PKT_W = 19,
    parameter int DEPTH = 4,
    parameter int STAGE = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [(1<<N_LOG)-1:0]         up_vld,
    input  logic [(1<<N_LOG)*PKT_W-1:0]   up_pkt,
    output logic [(1<<N_LOG)-1:0]         up_take,
    output logic [(1<<N_LOG)-1:0]         dn_vld,
    output logic [(1<<N_LOG)*PKT_W-1:0]   dn_pkt,
    input  logic [(1<<N_LOG)-1:0]         dn_take
);
    localparam int N  = 1 << N_LOG;
    localparam int RB = PKT_W - STAGE;   // destination bit n-STAGE

    logic [N-1:0]     sh_vld, sh_take, rb, ga, gb;
    logic [PKT_W-1:0] sh_pkt [N];

    // shuffle wiring in front of the elements
    for (genvar i = 0; i < N; i++) begin : g_shuf
        localparam int J = shuffle_idx(i, N_LOG);
        assign sh_vld[J]  = up_vld[i];
        assign sh_pkt[J]  = up_pkt[i*PKT_W +: PKT_W];
        assign up_take[i] = sh_take[J];
        assign rb[i]      = sh_pkt[i][RB];
    end

    // one queue per element output line
    for (genvar q = 0; q < N; q++) begin : g_line
        localparam int  UP = q - (q % 2);
        localparam bit  OB = (q % 2) == 1;
        omega_obuf #(.PKT_W(PKT_W), .DEPTH(DEPTH)) i_obuf (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_a    (sh_vld[UP]   & (rb[UP]   == OB)),
            .pkt_a    (sh_pkt[UP]),
            .req_b    (sh_vld[UP+1] & (rb[UP+1] == OB)),
            .pkt_b    (sh_pkt[UP+1]),
            .gnt_a    (ga[q]),
            .gnt_b    (gb[q]),
            .head_vld (dn_vld[q]),
            .head_pkt (dn_pkt[q*PKT_W +: PKT_W]),
            .pop      (dn_take[q])
        );
    end

    // each element input is taken by the queue its routing bit selects
    for (genvar l = 0; l < N/2; l++) begin : g_elem
        assign sh_take[2*l]   = rb[2*l]   ? ga[2*l+1] : ga[2*l];
        assign sh_take[2*l+1] = rb[2*l+1] ? gb[2*l+1] : gb[2*l];
    end

endmodule

// File: rtl/omega_fabric.sv
module omega_fabric
    import omega_pkg::*;
#(
    parameter int N_LOG     = 3,
    parameter int PAY_W     = 16,
    parameter int IBC_DEPTH = 4,
    parameter int BUF_DEPTH = 4
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic [(1<<N_LOG)-1:0]                       in_valid,
    output logic [(1<<N_LOG)-1:0]                       in_ready,
    input  logic [(1<<N_LOG)*N_LOG-1:0]                 in_dest,
    input  logic [(1<<N_LOG)*PAY_W-1:0]                 in_data,
    output logic [(1<<N_LOG)*$clog2(IBC_DEPTH+1)-1:0]   in_occ,
    output logic [(1<<N_LOG)-1:0]                       out_valid,
    output logic [(1<<N_LOG)*N_LOG-1:0]                 out_dest,
    output logic [(1<<N_LOG)*PAY_W-1:0]                 out_data
);
    localparam int N     = 1 << N_LOG;
    localparam int PKT_W = N_LOG + PAY_W;
    localparam int OCC_W = $clog2(IBC_DEPTH + 1);

    // index 0 is the input queues, index k the queues of stage k
    logic [N_LOG:0][N-1:0]       lv;
    logic [N_LOG:0][N-1:0]       lt;
    logic [N_LOG:0][N*PKT_W-1:0] lp;

    for (genvar i = 0; i < N; i++) begin : g_ibc
        omega_ibc #(.PKT_W(PKT_W), .DEPTH(IBC_DEPTH)) i_ibc (
            .clk       (clk),
            .rst_n     (rst_n),
            .push_vld  (in_valid[i]),
            .push_pkt  ({in_dest[i*N_LOG +: N_LOG], in_data[i*PAY_W +: PAY_W]}),
            .push_rdy  (in_ready[i]),
            .head_vld  (lv[0][i]),
            .head_pkt  (lp[0][i*PKT_W +: PKT_W]),
            .head_take (lt[0][i]),
            .occ       (in_occ[i*OCC_W +: OCC_W])
        );
    end

    for (genvar k = 1; k <= N_LOG; k++) begin : g_stg
        omega_stage #(
            .N_LOG (N_LOG),
            .PKT_W (PKT_W),
            .DEPTH (BUF_DEPTH),
            .STAGE (k)
        ) i_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .up_vld  (lv[k-1]),
            .up_pkt  (lp[k-1]),
            .up_take (lt[k-1]),
            .dn_vld  (lv[k]),
            .dn_pkt  (lp[k]),
            .dn_take (lt[k])
        );
    end

    // network outputs never block
    assign lt[N_LOG]  = lv[N_LOG];
    assign out_valid  = lv[N_LOG];

    for (genvar i = 0; i < N; i++) begin : g_out
        assign out_dest[i*N_LOG +: N_LOG] = lp[N_LOG][i*PKT_W + PAY_W +: N_LOG];
        assign out_data[i*PAY_W +: PAY_W] = lp[N_LOG][i*PKT_W +: PAY_W];
    end

endmodule

// File: rtl/omega_fabric_chk.sv
module omega_fabric_chk #(
    parameter int N_LOG     = 3,
    parameter int PAY_W     = 16,
    parameter int IBC_DEPTH = 4,
    parameter int BUF_DEPTH = 4
) (
    input logic                                                clk,
    input logic                                                rst_n,
    input logic [(1<<N_LOG)-1:0]                               in_ready,
    input logic [(1<<N_LOG)*$clog2(IBC_DEPTH+1)-1:0]           in_occ,
    input logic [(1<<N_LOG)-1:0]                               out_valid,
    input logic [(1<<N_LOG)*N_LOG-1:0]                         out_dest,
    input logic [N_LOG:0][(1<<N_LOG)-1:0]                      lv,
    input logic [N_LOG:0][(1<<N_LOG)-1:0]                      lt,
    input logic [N_LOG:0][(1<<N_LOG)*(N_LOG+PAY_W)-1:0]        lp
);
    localparam int N     = 1 << N_LOG;
    localparam int PKT_W = N_LOG + PAY_W;
    localparam int OCC_W = $clog2(IBC_DEPTH + 1);
    localparam logic [OCC_W-1:0] M_CNT = OCC_W'(IBC_DEPTH);

    for (genvar i = 0; i < N; i++) begin : g_port
        AST_READY_TRACKS_OCC: assert property (@(posedge clk) disable iff (!rst_n)
            in_ready[i] == (in_occ[i*OCC_W +: OCC_W] < M_CNT));                               // R5
        AST_OCC_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
            in_occ[i*OCC_W +: OCC_W] <= M_CNT);                                               // R5
        AST_NO_GROWTH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
            !in_ready[i] |=> in_occ[i*OCC_W +: OCC_W] <= $past(in_occ[i*OCC_W +: OCC_W]));    // R5
        AST_OUT_AT_DEST: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[i] |-> out_dest[i*N_LOG +: N_LOG] == N_LOG'(i));                         // R1
    end

    for (genvar k = 0; k < N_LOG; k++) begin : g_lvl
        for (genvar i = 0; i < N; i++) begin : g_ln
            AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
                lv[k][i] && !lt[k][i] |=> lv[k][i] && $stable(lp[k][i*PKT_W +: PKT_W]));     // R6
            AST_TAKE_NEEDS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
                lt[k][i] |-> lv[k][i]);                                                         // R2
        end
    end

endmodule

bind omega_fabric omega_fabric_chk #(
    .N_LOG     (N_LOG),
    .PAY_W     (PAY_W),
    .IBC_DEPTH (IBC_DEPTH),
    .BUF_DEPTH (BUF_DEPTH)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .in_occ    (in_occ),
    .out_valid (out_valid),
    .out_dest  (out_dest),
    .lv        (lv),
    .lt        (lt),
    .lp        (lp)
);

// File: tb/test_omega_fabric.sv
module test_omega_fabric;
    localparam int CLK_PERIOD = 10;
    localparam int NL    = 3;
    localparam int N     = 1 << NL;
    localparam int PW    = 16;
    localparam int IBD   = 4;
    localparam int SBD   = 4;
    localparam int OW    = $clog2(IBD + 1);
    localparam int SEQ_W = PW - NL;

    logic              clk = 1'b0;
    logic              rst_n = 1'b1;
    logic [N-1:0]      in_valid = '0;
    logic [N-1:0]      in_ready;
    logic [N*NL-1:0]   in_dest = '0;
    logic [N*PW-1:0]   in_data = '0;
    logic [N*OW-1:0]   in_occ;
    logic [N-1:0]      out_valid;
    logic [N*NL-1:0]   out_dest;
    logic [N*PW-1:0]   out_data;

    omega_fabric #(.N_LOG(NL), .PAY_W(PW), .IBC_DEPTH(IBD), .BUF_DEPTH(SBD)) i_omega_fabric (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_dest(in_dest), .in_data(in_data), .in_occ(in_occ),
        .out_valid(out_valid), .out_dest(out_dest), .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int  nchk = 0, nfail = 0;
    bit  done = 0;
    bit  run = 0, gen_on = 0, exact_lat = 0, win_on = 0;
    int  rate = 0, dmode = 0;
    bit  [N-1:0] shot_req = '0;
    int  shot_dst [N];
    bit  [N-1:0] pend = '0, acc = '0;
    int  pdst [N], pseq [N];
    int  nxt_seq [N][N], exp_seq [N][N], sent [N][N], rcvd [N][N];
    int  inj_t [N*N][256];
    int  tot_sent = 0, tot_rcvd = 0, ready_low = 0;
    int  win_out [N], win_src [N];
    logic [31:0] rs = 32'h2f6e_1b93;

    function automatic int rnd();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return int'(rs & 32'h7fff_ffff);
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    // one negedge: score outputs, check queues, then drive inputs for the coming edge
    task automatic step();
        int src, dst, seq, lat, occ, d;
        for (int j = 0; j < N; j++) begin
            if (out_valid[j]) begin
                dst = int'(out_dest[j*NL +: NL]);
                src = int'(out_data[j*PW + SEQ_W +: NL]);
                seq = int'(out_data[j*PW +: SEQ_W]);
                chk(dst == j, "R1", "output index vs destination", dst, j);
                chk(seq == exp_seq[src][dst], "R3", "flow sequence number", seq, exp_seq[src][dst]);
                exp_seq[src][dst] = seq + 1;
                lat = cyc + 1 - inj_t[src*N + dst][seq % 256];
                if (exact_lat) chk(lat == NL + 1, "R4", "latency in empty fabric", lat, NL + 1);
                else           chk(lat >= NL + 1, "R4", "latency lower bound", lat, NL + 1);
                rcvd[src][dst]++;
                tot_rcvd++;
                if (win_on) begin
                    win_out[j]++;
                    win_src[src]++;
                end
            end
        end
        for (int i = 0; i < N; i++) begin
            occ = int'(in_occ[i*OW +: OW]);
            chk(in_ready[i] == (occ < IBD), "R5", "ready vs occupancy", int'(in_ready[i]), occ);
            if (!in_ready[i]) ready_low++;
            if (acc[i]) pend[i] = 1'b0;
            if (!pend[i]) begin
                d = -1;
                if (shot_req[i]) begin
                    d = shot_dst[i];
                    shot_req[i] = 1'b0;
                end else if (gen_on && (rnd() % 100) < rate) begin
                    case (dmode)
                        1:       d = 0;
                        2:       d = i;
                        3:       d = (rnd() % 2 == 0) ? 5 : rnd() % N;
                        default: d = rnd() % N;
                    endcase
                end
                if (d >= 0) begin
                    pend[i] = 1'b1;
                    pdst[i] = d;
                    pseq[i] = nxt_seq[i][d];
                    nxt_seq[i][d]++;
                    sent[i][d]++;
                    tot_sent++;
                end
            end
            in_valid[i] = pend[i];
            in_dest[i*NL +: NL] = NL'(pdst[i]);
            in_data[i*PW +: PW] = {NL'(i), SEQ_W'(pseq[i])};
            acc[i] = pend[i] & in_ready[i];
            if (acc[i]) inj_t[i*N + pdst[i]][pseq[i] % 256] = cyc + 1;
        end
    endtask

    initial begin
        wait (run);
        forever begin
            @(negedge clk);
            step();
        end
    end

    task automatic drain(input string req);
        int t = 0;
        while ((tot_sent != tot_rcvd || pend != '0) && t < 4000) begin
            @(posedge clk);
            t++;
        end
        chk(tot_sent == tot_rcvd, req, "drain: delivered vs sent", tot_rcvd, tot_sent);
        repeat (4) @(posedge clk);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            pdst[i] = 0; pseq[i] = 0; shot_dst[i] = 0;
            for (int j = 0; j < N; j++) begin
                nxt_seq[i][j] = 0; exp_seq[i][j] = 0; sent[i][j] = 0; rcvd[i][j] = 0;
            end
        end
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: state right after reset
        chk(in_ready == '1, "R9", "ready after reset", int'(in_ready), 255);
        chk(out_valid == '0, "R9", "outputs idle after reset", int'(out_valid), 0);
        chk(in_occ == '0, "R9", "occupancy after reset", int'(in_occ), 0);
        @(posedge clk);
        run = 1;

        // R4/R1: every source-destination pair alone in the fabric
        exact_lat = 1;
        for (int s = 0; s < N; s++) begin
            for (int d = 0; d < N; d++) begin
                @(posedge clk);
                shot_dst[s] = d;
                shot_req[s] = 1'b1;
                repeat (8) @(posedge clk);
            end
        end
        drain("R2");
        exact_lat = 0;

        // R7: destination = source at full rate is conflict free
        dmode = 2; rate = 100; gen_on = 1;
        repeat (40) @(posedge clk);
        for (int j = 0; j < N; j++) begin win_out[j] = 0; win_src[j] = 0; end
        win_on = 1;
        repeat (200) @(posedge clk);
        win_on = 0;
        for (int j = 0; j < N; j++) chk(win_out[j] == 200, "R7", "full-rate deliveries per output", win_out[j], 200);
        gen_on = 0;
        drain("R2");

        // R8/R7/R5: saturated hot spot on output 0
        dmode = 1; rate = 100; ready_low = 0; gen_on = 1;
        repeat (100) @(posedge clk);
        for (int j = 0; j < N; j++) begin win_out[j] = 0; win_src[j] = 0; end
        win_on = 1;
        repeat (300) @(posedge clk);
        win_on = 0;
        gen_on = 0;
        chk(win_out[0] == 300, "R7", "hot output never idle", win_out[0], 300);
        for (int s = 0; s < N; s++)
            chk(win_src[s] >= 30 && win_src[s] <= 45, "R8", "hot-spot share per source", win_src[s], 300 / N);
        chk(ready_low > 0, "R5", "input queues filled under hot spot", ready_low, 1);
        drain("R2");

        // R2/R3: random uniform and skewed traffic
        dmode = 0; rate = 60; gen_on = 1;
        repeat (3000) @(posedge clk);
        gen_on = 0;
        drain("R2");
        dmode = 3; rate = 40; gen_on = 1;
        repeat (2000) @(posedge clk);
        gen_on = 0;
        drain("R2");

        // R2: per-flow exactly-once accounting
        for (int s = 0; s < N; s++)
            for (int d = 0; d < N; d++)
                chk(rcvd[s][d] == sent[s][d], "R2", "per-flow delivered count", rcvd[s][d], sent[s][d]);
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R2", "watchdog expired", cyc, 150000);
        summary();
    end

endmodule